// File: doc/BRIEF.md
# Packed SIMD Media Arithmetic Unit

This block performs lane-parallel integer arithmetic on a 32-bit word for media kernels such as pixel blending, motion-compensation averaging, lighting and transform butterflies. Each operand word is split into four 8-bit lanes or two 16-bit lanes, and every lane is computed on its own, with no carry or borrow crossing a lane boundary. Three source words enter with an opcode and mode bits. One destination word leaves through a single output register.

The lane operations are add, subtract, mean, two compares and a per-lane select. Add and subtract can wrap or saturate, with a signed or unsigned range. Mean can truncate or round half up. Three further operations always use 16-bit lanes: a per-lane signed multiply-add, and a dot product of the two 16-bit lanes that is added to, or subtracted from, a full 32-bit third operand. Signed saturation applies to these when it is enabled.

The handshake is a single valid bit in each direction. There is no back-pressure.

Top module: `simd_media_alu`

## Requirements
- R1: `out_valid` and `result` follow an accepted `in_valid` by exactly one clock. While `in_valid` is low, `result` keeps its last value and `out_valid` is low.
- R2: A synchronous active-high `rst` clears `result` to 0 and `out_valid` to 0 at the next rising edge.
- R3: `lane16`=0 selects four 8-bit lanes at bits [8k+7:8k]. `lane16`=1 selects two 16-bit lanes at bits [16k+15:16k]. No carry or borrow passes between lanes.
- R4: With `sat_en`=0, opcode 0 (add) and opcode 1 (subtract) return each lane's sum or difference modulo 2^n, where n is the lane width.
- R5: With `sat_en`=1, add and subtract clamp each lane on its own. When `signed_mode`=1 the clamp range is [-2^(n-1), 2^(n-1)-1]; when `signed_mode`=0 it is [0, 2^n-1].
- R6: Opcode 2 (mean) returns floor((a+b+r)/2) per lane. The sum is taken without overflow, r is the `round_up` bit, and the lane values are read as signed when `signed_mode`=1 and as unsigned when it is 0.
- R7: Opcode 3 sets a lane to all ones when a equals b and to zero otherwise. Opcode 4 does the same for signed a greater than signed b.
- R8: Opcode 5 (select) takes each lane from `src_a` when the MSB of the matching `src_c` lane is 1, and from `src_b` when it is 0.
- R9: Opcode 6 (multiply-add) uses 16-bit lanes whatever `lane16` holds. Each lane returns signed a*b + signed c. The result wraps to 16 bits, or is clamped to the signed 16-bit range when `sat_en`=1.
- R10: Opcode 7 returns c + (a0*b0 + a1*b1), and opcode 8 returns c − (a0*b0 + a1*b1). Here a0, a1, b0 and b1 are the signed 16-bit lanes and c is the whole signed 32-bit `src_c`. The result wraps, or is clamped to the signed 32-bit range when `sat_en`=1.
- R11: Opcodes 9 to 15 produce a `result` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op | input | 4 | Operation code |
| lane16 | input | 1 | 1 selects 16-bit lanes, 0 selects 8-bit lanes |
| sat_en | input | 1 | Saturate instead of wrap |
| signed_mode | input | 1 | Signed lane range for saturation and mean |
| round_up | input | 1 | Mean rounds half up instead of truncating |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| src_c | input | 32 | Third source word |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Destination word |

## Verification
Random operands almost never reach the saturated edges of the dot product, because two products near 2^30 must combine with a third operand near ±2^31. They also rarely produce lanes that are exactly equal for the compare. The stimulus therefore draws each lane from a small set of extreme values (0, ±1, the most negative and most positive code) about half the time, and uses fully random values the rest of the time. Directed cases then push the dot product past both 32-bit limits and cover the rounding tie in mean.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_MEAN   = 4'd2,
    OP_CMPEQ  = 4'd3,
    OP_CMPGT  = 4'd4,
    OP_SEL    = 4'd5,
    OP_MULADD = 4'd6,
    OP_DOTADD = 4'd7,
    OP_DOTSUB = 4'd8
  } simd_op_e;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  simd_op_e       op,
  input  logic           sat_en,
  input  logic           sgn,
  input  logic           rnd,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  output logic [W-1:0]   y
);
  localparam int XW = W + 2;
  localparam int HW = XW - W + 1;

  logic [XW-1:0] ea, eb, sum_x, dif_x, mean_x;

  // extend lanes by two bits so every sum and difference is exact
  assign ea     = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
  assign eb     = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
  assign sum_x  = ea + eb;
  assign dif_x  = ea - eb;
  assign mean_x = sum_x + {{(XW-1){1'b0}}, rnd};

  function automatic logic [W-1:0] clamp(input logic [XW-1:0] v, input logic sg);
    if (sg) begin
      if (v[XW-1:W-1] != {HW{v[XW-1]}})
        return v[XW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      if (v[XW-1]) return '0;
      if (v[W])    return '1;
    end
    return v[W-1:0];
  endfunction

  always_comb begin
    unique case (op)
      OP_ADD:   y = sat_en ? clamp(sum_x, sgn) : sum_x[W-1:0];
      OP_SUB:   y = sat_en ? clamp(dif_x, sgn) : dif_x[W-1:0];
      OP_MEAN:  y = mean_x[W:1];
      OP_CMPEQ: y = (a == b) ? '1 : '0;
      OP_CMPGT: y = ($signed(a) > $signed(b)) ? '1 : '0;
      OP_SEL:   y = c[W-1] ? a : b;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit #(
  parameter int DATA_W = 32
) (
  input  logic              sat_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] madd_y,
  output logic [DATA_W-1:0] dot_add_y,
  output logic [DATA_W-1:0] dot_sub_y
);
  localparam int LW  = 16;
  localparam int NL  = DATA_W / LW;
  localparam int PW  = 2 * LW;
  localparam int AW  = DATA_W + 2 + $clog2(NL);
  localparam int MW  = PW + 2;

  logic signed [PW-1:0] prod [NL];

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      logic signed [MW-1:0] acc;
      assign prod[g] = $signed(a[g*LW +: LW]) * $signed(b[g*LW +: LW]);
      assign acc = MW'(prod[g]) + MW'($signed(c[g*LW +: LW]));
      always_comb begin
        if (sat_en && acc > MW'(32767))
          madd_y[g*LW +: LW] = 16'h7FFF;
        else if (sat_en && acc < -MW'(32768))
          madd_y[g*LW +: LW] = 16'h8000;
        else
          madd_y[g*LW +: LW] = acc[LW-1:0];
      end
    end
  endgenerate

  logic signed [AW-1:0] dot_sum, tot_add, tot_sub, hi_lim, lo_lim;

  always_comb begin
    dot_sum = '0;
    for (int i = 0; i < NL; i++) dot_sum = dot_sum + AW'(prod[i]);
  end

  assign tot_add = AW'($signed(c)) + dot_sum;
  assign tot_sub = AW'($signed(c)) - dot_sum;
  assign hi_lim  = AW'($signed({1'b0, {(DATA_W-1){1'b1}}}));
  assign lo_lim  = AW'($signed({1'b1, {(DATA_W-1){1'b0}}}));

  function automatic logic [DATA_W-1:0] fit(input logic signed [AW-1:0] v,
                                            input logic signed [AW-1:0] hi,
                                            input logic signed [AW-1:0] lo,
                                            input logic s);
    if (s && v > hi) return hi[DATA_W-1:0];
    if (s && v < lo) return lo[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  assign dot_add_y = fit(tot_add, hi_lim, lo_lim, sat_en);
  assign dot_sub_y = fit(tot_sub, hi_lim, lo_lim, sat_en);
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic              lane16,
  input  logic              sat_en,
  input  logic              signed_mode,
  input  logic              round_up,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int N8  = DATA_W / 8;
  localparam int N16 = DATA_W / 16;

  simd_op_e op_e;
  assign op_e = simd_op_e'(op);

  logic [DATA_W-1:0] y8, y16, madd_y, dadd_y, dsub_y;
  logic [DATA_W-1:0] next_y;

  genvar g;
  generate
    for (g = 0; g < N8; g++) begin : g_b
      simd_lane_alu #(.W(8)) u_lane (
        .op(op_e), .sat_en(sat_en), .sgn(signed_mode), .rnd(round_up),
        .a(src_a[g*8 +: 8]), .b(src_b[g*8 +: 8]), .c(src_c[g*8 +: 8]),
        .y(y8[g*8 +: 8])
      );
    end
    for (g = 0; g < N16; g++) begin : g_h
      simd_lane_alu #(.W(16)) u_lane (
        .op(op_e), .sat_en(sat_en), .sgn(signed_mode), .rnd(round_up),
        .a(src_a[g*16 +: 16]), .b(src_b[g*16 +: 16]), .c(src_c[g*16 +: 16]),
        .y(y16[g*16 +: 16])
      );
    end
  endgenerate

  simd_mac_unit #(.DATA_W(DATA_W)) u_mac (
    .sat_en(sat_en), .a(src_a), .b(src_b), .c(src_c),
    .madd_y(madd_y), .dot_add_y(dadd_y), .dot_sub_y(dsub_y)
  );

  always_comb begin
    case (op_e)
      OP_MULADD: next_y = madd_y;
      OP_DOTADD: next_y = dadd_y;
      OP_DOTSUB: next_y = dsub_y;
      default:   next_y = lane16 ? y16 : y8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_y;
    end
  end

  function automatic logic lanes_are_masks(input logic [DATA_W-1:0] v, input logic h);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N8; i++)
      if (!h && v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    for (int i = 0; i < N16; i++)
      if (h && v[i*16 +: 16] != 16'h0000 && v[i*16 +: 16] != 16'hFFFF) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic bytes_not_below(input logic [DATA_W-1:0] v, input logic [DATA_W-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N8; i++)
      if (v[i*8 +: 8] < a[i*8 +: 8]) ok = 1'b0;
    return ok;
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                           // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));                    // R1
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0 && !out_valid));                             // R2
  AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_e == OP_CMPEQ || op_e == OP_CMPGT))
      |=> lanes_are_masks(result, $past(lane16)));                     // R7
  AST_USAT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_ADD && sat_en && !signed_mode && !lane16)
      |=> bytes_not_below(result, $past(src_a)));                      // R5
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 4'd8) |=> (result == '0));                       // R11
endmodule

// File: tb/tb_simd_media_alu.sv
`timescale 1ns/1ps
module tb_simd_media_alu;
  logic clk = 1'b0;
  logic rst, in_valid, lane16, sat_en, signed_mode, round_up;
  logic [3:0] op;
  logic [31:0] src_a, src_b, src_c, result;
  logic out_valid;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  simd_media_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane16(lane16),
    .sat_en(sat_en), .signed_mode(signed_mode), .round_up(round_up),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint sx(longint u, int n);
    return (u >= (64'sd1 <<< (n-1))) ? u - (64'sd1 <<< n) : u;
  endfunction

  function automatic longint clampv(longint v, longint lo, longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [31:0] model(logic [3:0] o, logic h, logic s, logic sg,
                                        logic r, logic [31:0] a, logic [31:0] b,
                                        logic [31:0] c);
    logic [31:0] y;
    int n, cnt;
    longint m, ua, ub, uc, va, vb, v, sum;
    y = '0;
    if (o >= 4'd6 && o <= 4'd8) begin
      if (o == 4'd6) begin
        for (int i = 0; i < 2; i++) begin
          v = sx((a >> (16*i)) & 32'hFFFF, 16) * sx((b >> (16*i)) & 32'hFFFF, 16)
              + sx((c >> (16*i)) & 32'hFFFF, 16);
          if (s) v = clampv(v, -32768, 32767);
          y[16*i +: 16] = 16'(v);
        end
      end else begin
        sum = sx(a & 32'hFFFF, 16) * sx(b & 32'hFFFF, 16)
            + sx(a >> 16, 16) * sx(b >> 16, 16);
        v = (o == 4'd7) ? sx(c, 32) + sum : sx(c, 32) - sum;
        if (s) v = clampv(v, -64'sd2147483648, 64'sd2147483647);
        y = 32'(v);
      end
      return y;
    end
    n = h ? 16 : 8;
    cnt = 32 / n;
    m = (64'sd1 <<< n) - 1;
    for (int i = 0; i < cnt; i++) begin
      ua = (a >> (n*i)) & m;
      ub = (b >> (n*i)) & m;
      uc = (c >> (n*i)) & m;
      va = sg ? sx(ua, n) : ua;
      vb = sg ? sx(ub, n) : ub;
      case (o)
        4'd0, 4'd1: begin
          v = (o == 4'd0) ? va + vb : va - vb;
          if (s) v = sg ? clampv(v, -(64'sd1 <<< (n-1)), (64'sd1 <<< (n-1)) - 1)
                        : clampv(v, 0, m);
        end
        4'd2: v = (va + vb + longint'(r)) >>> 1;
        4'd3: v = (ua == ub) ? m : 0;
        4'd4: v = (sx(ua, n) > sx(ub, n)) ? m : 0;
        4'd5: v = uc[n-1] ? ua : ub;
        default: v = 0;
      endcase
      y = y | (32'(v & m) << (n*i));
    end
    return y;
  endfunction

  function automatic string tag_of(logic [3:0] o, logic s);
    case (o)
      4'd0, 4'd1: return s ? "R5" : "R4";
      4'd2: return "R6";
      4'd3, 4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7, 4'd8: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(logic [3:0] o, logic h, logic s, logic sg, logic r,
                        logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] e;
    e = model(o, h, s, sg, r, a, b, c);
    @(negedge clk);
    in_valid = 1; op = o; lane16 = h; sat_en = s; signed_mode = sg; round_up = r;
    src_a = a; src_b = b; src_c = c;
    @(negedge clk);
    in_valid = 0;
    check("R1", {31'd0, out_valid}, 32'd1);
    check(tag_of(o, s), result, e);
  endtask

  function automatic logic [31:0] pick_word();
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      case ($urandom % 8)
        0: w[8*i +: 8] = 8'h00;
        1: w[8*i +: 8] = 8'h01;
        2: w[8*i +: 8] = 8'hFF;
        3: w[8*i +: 8] = 8'h80;
        4: w[8*i +: 8] = 8'h7F;
        default: w[8*i +: 8] = 8'($urandom);
      endcase
    end
    return w;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held, a, b;
    void'($urandom(32'd7341));
    rst = 1; in_valid = 0; op = 0; lane16 = 0; sat_en = 0; signed_mode = 0;
    round_up = 0; src_a = 0; src_b = 0; src_c = 0;
    repeat (3) @(negedge clk);
    check("R2", result, 32'd0);
    check("R2", {31'd0, out_valid}, 32'd0);
    rst = 0;

    // R3: lanes isolated; 8-bit wrap vs 16-bit carry
    run_op(4'd0, 0, 0, 0, 0, 32'h00FF00FF, 32'h00010001, 0);
    check("R3", result, 32'h00000000);
    run_op(4'd0, 1, 0, 0, 0, 32'h00FF00FF, 32'h00010001, 0);
    check("R3", result, 32'h01000100);
    // R5 signed and unsigned clamp
    run_op(4'd0, 0, 1, 1, 0, 32'h7F80107F, 32'h01FF1001, 0);
    run_op(4'd1, 0, 1, 0, 0, 32'h00050010, 32'h01060008, 0);
    run_op(4'd0, 1, 1, 1, 0, 32'h7FFF8000, 32'h0001FFFF, 0);
    // R6 rounding tie, signed negatives
    run_op(4'd2, 0, 0, 0, 0, 32'h01030102, 32'h02020201, 0);
    run_op(4'd2, 0, 0, 0, 1, 32'h01030102, 32'h02020201, 0);
    run_op(4'd2, 1, 0, 1, 1, 32'hFFFF8000, 32'hFFFE8000, 0);
    // R7 / R8
    run_op(4'd3, 0, 0, 0, 0, 32'h11223344, 32'h11003300, 0);
    run_op(4'd4, 1, 0, 0, 0, 32'h80000001, 32'h7FFF0000, 0);
    run_op(4'd5, 0, 0, 0, 0, 32'hAAAAAAAA, 32'h55555555, 32'h80008000);
    // R9 with lane16 low still uses 16-bit lanes
    run_op(4'd6, 0, 1, 0, 0, 32'h7FFF0002, 32'h7FFF0003, 32'h00000004);
    run_op(4'd6, 0, 0, 0, 0, 32'h7FFF0002, 32'h7FFF0003, 32'h00000004);
    // R10 saturation both directions
    run_op(4'd7, 1, 1, 0, 0, 32'h80008000, 32'h80008000, 32'h7FFFFFFF);
    run_op(4'd8, 1, 1, 0, 0, 32'h80008000, 32'h80008000, 32'h80000000);
    run_op(4'd7, 1, 0, 0, 0, 32'h80008000, 32'h80008000, 32'h7FFFFFFF);
    // R11
    run_op(4'd12, 0, 0, 0, 0, 32'hFFFFFFFF, 32'h12345678, 32'h1);

    // R1: idle cycles leave result unchanged
    held = result;
    @(negedge clk);
    src_a = 32'hDEADBEEF; op = 4'd0;
    @(negedge clk);
    check("R1", result, held);
    check("R1", {31'd0, out_valid}, 32'd0);

    for (int k = 0; k < 4000; k++) begin
      a = ($urandom % 2) ? pick_word() : $urandom;
      b = ($urandom % 2) ? pick_word() : ((k % 7 == 0) ? a : $urandom);
      run_op(4'($urandom % 10 == 0 ? 9 + $urandom % 7 : $urandom % 9),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             a, b, ($urandom % 2) ? pick_word() : $urandom);
    end

    // R2 mid-run reset
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("R2", result, 32'd0);
    rst = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule